// File: doc/BRIEF.md
# Buffered-Compare PWM Timer Channel

This block is one channel of a 16-bit up-counting timer. It has four general registers: two primaries (A and B) and two companions (C and D). A counter runs while a start bit is set and a clock-enable input is high. In single-edge PWM operation, B sets the period and A sets the duty point. When the counter has just matched A, the output rises. When it has just matched B, the output falls and the counter wraps to zero.

A primary can be paired with its companion so that C feeds A and D feeds B. Software then writes the next duty value into the companion at any time. The hardware copies the companion into the primary on that primary's own match, in the same cycle as the output edge. The new duty therefore never takes effect in the middle of a pulse.

Each register can also be set to capture the counter on a rising edge of the capture input. When a primary captures with pairing on, its previous value moves into the companion. Software uses a plain write/read register port. Writes are always accepted in the cycle they are presented and reads are combinational, so there is no back-pressure on this port.

Top module: `pwm_buf_timer`

## Requirements
- R1: After reset, registers A, B, C, D, the control word and the counter all read 0000h and `pwm_out` is low.
- R2: The counter advances by one on each clock only while control bit 0 (run) is 1 and `cnt_en` is 1. In any other cycle it holds its value. Clearing run does not alter `pwm_out` or any register.
- R3: With control bit 1 (PWM mode) set and B in compare mode, the clock edge that sees the counter equal to B loads it with 0000h. The period is therefore B+1 counting clocks.
- R4: In PWM mode, `pwm_out` goes high at the clock edge that sees the counter equal to A, and low at the edge that sees it equal to B. When both match in the same cycle, low wins. Matches are only recognised while the counter is counting.
- R5: With control bit 2 set and A in compare mode, each A match copies C into A at that same edge. A value written to C does not change A before that match. With bit 2 clear, a match leaves A unchanged.
- R6: With control bit 3 set and B in compare mode, each B match copies D into B at that same edge.
- R7: A software write to A in the same cycle as a C-to-A copy is lost, and the copied value is kept.
- R8: Control bits 4 to 7 put A, B, C and D respectively into capture mode. When `capture_in` has been low and then samples high, each capturing register loads the counter value at that edge. A capturing primary whose pairing bit is set first moves its old value into its companion.
- R9: Register port map: address 0 is A, 1 is B, 2 is C, 3 is D, 4 is the control word (bits 7:0) and 5 is the counter. Any other address reads 0. A write to A or B when no copy is due takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counting clock enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| capture_in | input | 1 | Capture trigger, rising edge |
| pwm_out | output | 1 | PWM output |

## Verification
Reads are combinational, so a register or counter value can be checked in the same half-cycle that its address is driven. A write becomes visible one edge after it is presented. The PWM edge, the wrap to zero and the companion copy are due at the first clock edge that sees the counter equal to the register. Since the counter moves forward at that same edge, each of these results shows one clock after the counter displayed the matching value. A capture is due one edge after the input is first sampled high. The bench drives all inputs on the falling edge and samples half a cycle after each rising edge. It counts every edge from the start write so that each expected counter value and pin level refers to one specific edge.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

  typedef enum logic [2:0] {
    SEL_A     = 3'd0,
    SEL_B     = 3'd1,
    SEL_C     = 3'd2,
    SEL_D     = 3'd3,
    SEL_CTRL  = 3'd4,
    SEL_COUNT = 3'd5
  } reg_sel_e;

  // Control word, MSB first: capture selects for D,C,B,A then pairing and mode bits.
  typedef struct packed {
    logic [3:0] cap_sel;
    logic       pair_bd;
    logic       pair_ac;
    logic       pwm_en;
    logic       run;
  } ctrl_t;

  localparam int unsigned ADDR_W    = $bits(reg_sel_e);
  localparam int unsigned CTRL_BITS = $bits(ctrl_t);
  localparam int unsigned NUM_PAIRS = 2;
  localparam int unsigned NUM_GREGS = 2 * NUM_PAIRS;

endpackage

// File: rtl/pbt_counter.sv
module pbt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cnt_en,
  input  logic         wrap,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         tick
);

  assign tick = run & cnt_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (tick) begin
      if (wrap) count <= '0;
      else      count <= count + W'(1);
    end
  end

endmodule

// File: rtl/pbt_match.sv
module pbt_match #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 2
) (
  input  logic                tick,
  input  logic [N-1:0]        cap_sel,
  input  logic [N-1:0][W-1:0] cmp_val,
  input  logic [W-1:0]        count,
  output logic [N-1:0]        hit
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = tick & ~cap_sel[g] & (count == cmp_val[g]);
  end

endmodule

// File: rtl/pbt_edge.sv
module pbt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_q,
  output logic rise
);

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  assign rise = pin & ~pin_q;

endmodule

// File: rtl/pbt_gregs.sv
module pbt_gregs #(
  parameter int unsigned W  = 16,
  parameter int unsigned NP = 2,
  localparam int unsigned NR = 2 * NP,
  localparam int unsigned IW = $clog2(NR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [W-1:0]         wr_data,
  input  logic [NP-1:0]        pair_en,
  input  logic [NR-1:0]        cap_sel,
  input  logic [NP-1:0]        hit,
  input  logic                 rise,
  input  logic [W-1:0]         count,
  output logic [NR-1:0][W-1:0] regs
);

  for (genvar p = 0; p < NP; p++) begin : g_pair
    localparam logic [IW-1:0] PRI_IDX = IW'(p);
    localparam logic [IW-1:0] BUF_IDX = IW'(p + NP);

    logic [W-1:0] pri_q;
    logic [W-1:0] buf_q;
    logic         xfer;
    logic         pri_cap;

    assign xfer    = pair_en[p] & hit[p];
    assign pri_cap = cap_sel[p] & rise;

    // Primary: hardware events outrank software writes.
    always_ff @(posedge clk) begin
      if (!rst_n)                            pri_q <= '0;
      else if (xfer)                         pri_q <= buf_q;
      else if (pri_cap)                      pri_q <= count;
      else if (wr_en && wr_idx == PRI_IDX)   pri_q <= wr_data;
    end

    // Companion: software writes always land.
    always_ff @(posedge clk) begin
      if (!rst_n)                                    buf_q <= '0;
      else if (wr_en && wr_idx == BUF_IDX)           buf_q <= wr_data;
      else if (pri_cap && pair_en[p])                buf_q <= pri_q;
      else if (rise && !pair_en[p] && cap_sel[p+NP]) buf_q <= count;
    end

    assign regs[p]      = pri_q;
    assign regs[p + NP] = buf_q;
  end

endmodule

// File: rtl/pbt_pwm_out.sv
module pbt_pwm_out (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_en,
  input  logic set_hit,
  input  logic clr_hit,
  output logic pwm_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (pwm_en) begin
      if (clr_hit)      pwm_q <= 1'b0;
      else if (set_hit) pwm_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pwm_buf_timer.sv
module pwm_buf_timer
  import pbt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              capture_in,
  output logic              pwm_out
);

  localparam int unsigned IW = $clog2(NUM_GREGS);

  ctrl_t                         ctrl_q;
  logic [NUM_GREGS-1:0][CNT_W-1:0] gr;
  logic [CNT_W-1:0]              count;
  logic                          tick;
  logic [NUM_PAIRS-1:0]          hit;
  logic                          cap_q;
  logic                          cap_rise;
  logic                          greg_wr;
  logic                          cnt_wr;
  logic                          wrap;

  assign greg_wr = reg_wr && (reg_addr < ADDR_W'(NUM_GREGS));
  assign cnt_wr  = reg_wr && (reg_addr == SEL_COUNT);
  assign wrap    = ctrl_q.pwm_en & hit[1];

  always_ff @(posedge clk) begin
    if (!rst_n)                             ctrl_q <= '0;
    else if (reg_wr && reg_addr == SEL_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
  end

  pbt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .cnt_en   (cnt_en),
    .wrap     (wrap),
    .load     (cnt_wr),
    .load_val (reg_wdata),
    .count    (count),
    .tick     (tick)
  );

  pbt_match #(.W(CNT_W), .N(NUM_PAIRS)) u_match (
    .tick    (tick),
    .cap_sel (ctrl_q.cap_sel[NUM_PAIRS-1:0]),
    .cmp_val (gr[NUM_PAIRS-1:0]),
    .count   (count),
    .hit     (hit)
  );

  pbt_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (capture_in),
    .pin_q (cap_q),
    .rise  (cap_rise)
  );

  pbt_gregs #(.W(CNT_W), .NP(NUM_PAIRS)) u_gregs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (greg_wr),
    .wr_idx  (reg_addr[IW-1:0]),
    .wr_data (reg_wdata),
    .pair_en ({ctrl_q.pair_bd, ctrl_q.pair_ac}),
    .cap_sel (ctrl_q.cap_sel),
    .hit     (hit),
    .rise    (cap_rise),
    .count   (count),
    .regs    (gr)
  );

  pbt_pwm_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_en  (ctrl_q.pwm_en),
    .set_hit (hit[0]),
    .clr_hit (hit[1]),
    .pwm_q   (pwm_out)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_A:     reg_rdata = gr[0];
      SEL_B:     reg_rdata = gr[1];
      SEL_C:     reg_rdata = gr[2];
      SEL_D:     reg_rdata = gr[3];
      SEL_CTRL:  reg_rdata = {{(CNT_W-CTRL_BITS){1'b0}}, ctrl_q};
      SEL_COUNT: reg_rdata = count;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwm_buf_timer_chk.sv
module pwm_buf_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         pwm_en,
  input logic         pair_ac,
  input logic [3:0]   cap_sel,
  input logic         cnt_en,
  input logic         cnt_wr,
  input logic [W-1:0] count,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [W-1:0] reg_c,
  input logic         capture_in,
  input logic         cap_q,
  input logic         pwm_out
);

  logic run_now;
  logic a_eq;
  logic b_eq;

  assign run_now = start & cnt_en;
  assign a_eq    = !cap_sel[0] && (count == reg_a);
  assign b_eq    = !cap_sel[1] && (count == reg_b);

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_now && !cnt_wr) |=> $stable(count)); // R2

  AST_WRAP_AT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && pwm_en && b_eq && !cnt_wr) |=> (count == '0)); // R3

  AST_RISE_AFTER_A: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && pwm_en && a_eq && !b_eq) |=> pwm_out); // R4

  AST_FALL_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && pwm_en && b_eq) |=> !pwm_out); // R4

  AST_COPY_C_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && pair_ac && a_eq) |=> (reg_a == $past(reg_c))); // R5 R7

  AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_sel[0] && capture_in && !cap_q) |=> (reg_a == $past(count))); // R8

endmodule

bind pwm_buf_timer pwm_buf_timer_chk #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (ctrl_q.run),
  .pwm_en     (ctrl_q.pwm_en),
  .pair_ac    (ctrl_q.pair_ac),
  .cap_sel    (ctrl_q.cap_sel),
  .cnt_en     (cnt_en),
  .cnt_wr     (cnt_wr),
  .count      (count),
  .reg_a      (gr[0]),
  .reg_b      (gr[1]),
  .reg_c      (gr[2]),
  .capture_in (capture_in),
  .cap_q      (cap_q),
  .pwm_out    (pwm_out)
);

// File: tb/pwm_buf_timer_test.sv
module pwm_buf_timer_test;

  localparam int unsigned WD_CYCLES = 20000;
  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_PN = 2'd2;
  localparam logic [1:0] OP_ID = 2'd3;
  localparam int NV = 38;

  // {req[3:0], op[1:0], addr[2:0], data[15:0]}
  localparam logic [24:0] VEC [NV] = '{
    {4'd9, OP_WR, 3'd1, 16'd9},    // R9 period reg B
    {4'd9, OP_WR, 3'd0, 16'd3},    // R9 duty reg A
    {4'd9, OP_WR, 3'd2, 16'd3},    // R9 companion C
    {4'd2, OP_RD, 3'd5, 16'd0},    // R2 stopped counter held
    {4'd9, OP_WR, 3'd4, 16'h0007}, // run+pwm+pair AC (edge E0)
    {4'd2, OP_ID, 3'd0, 16'd3},
    {4'd2, OP_RD, 3'd5, 16'd3},    // R2 counts
    {4'd4, OP_PN, 3'd0, 16'd0},    // R4 still low
    {4'd4, OP_ID, 3'd0, 16'd1},
    {4'd4, OP_PN, 3'd0, 16'd1},    // R4 high after A match
    {4'd5, OP_RD, 3'd0, 16'd3},    // R5 copied C (3)
    {4'd5, OP_WR, 3'd2, 16'd6},    // new duty into C
    {4'd5, OP_RD, 3'd0, 16'd3},    // R5 A not yet changed
    {4'd9, OP_RD, 3'd2, 16'd6},
    {4'd3, OP_ID, 3'd0, 16'd4},
    {4'd3, OP_RD, 3'd5, 16'd9},    // R3 at B
    {4'd4, OP_PN, 3'd0, 16'd1},
    {4'd3, OP_ID, 3'd0, 16'd1},
    {4'd3, OP_RD, 3'd5, 16'd0},    // R3 wrapped
    {4'd4, OP_PN, 3'd0, 16'd0},    // R4 low after B match
    {4'd4, OP_ID, 3'd0, 16'd3},
    {4'd4, OP_PN, 3'd0, 16'd0},
    {4'd5, OP_ID, 3'd0, 16'd1},
    {4'd5, OP_PN, 3'd0, 16'd1},    // R5 old duty used this period
    {4'd5, OP_RD, 3'd0, 16'd6},    // R5 transfer at A match
    {4'd3, OP_ID, 3'd0, 16'd6},
    {4'd3, OP_RD, 3'd5, 16'd0},
    {4'd4, OP_PN, 3'd0, 16'd0},
    {4'd5, OP_ID, 3'd0, 16'd6},
    {4'd5, OP_RD, 3'd5, 16'd6},
    {4'd5, OP_PN, 3'd0, 16'd0},    // R5 no longer high at 3
    {4'd5, OP_ID, 3'd0, 16'd1},
    {4'd5, OP_PN, 3'd0, 16'd1},    // R5 new duty point
    {4'd2, OP_WR, 3'd4, 16'h0006}, // clear run
    {4'd2, OP_RD, 3'd5, 16'd8},
    {4'd2, OP_ID, 3'd0, 16'd3},
    {4'd2, OP_RD, 3'd5, 16'd8},    // R2 held
    {4'd2, OP_PN, 3'd0, 16'd1}     // R2 output kept
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        capture_in;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwm_buf_timer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .capture_in (capture_in),
    .pwm_out    (pwm_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pin(input string tag, input logic exp);
    #1;
    chk(tag, {15'd0, pwm_out}, {15'd0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_en = 1'b1; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; capture_in = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int k = 0; k < 6; k++) rd("R1 reset reg", 3'(k), 16'h0000);
    pin("R1 reset pin", 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [1:0]  op;
      logic [2:0]  ad;
      logic [15:0] dt;
      {rq, op, ad, dt} = VEC[i];
      case (op)
        OP_WR: wr(ad, dt);
        OP_RD: rd($sformatf("R%0d table[%0d]", rq, i), ad, dt);
        OP_PN: pin($sformatf("R%0d table[%0d] pin", rq, i), dt[0]);
        default: step(int'(dt));
      endcase
    end

    // R1: reset from a busy state
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) rd("R1 re-reset reg", 3'(k), 16'h0000);
    pin("R1 re-reset pin", 1'b0);

    // R8: capture on A (paired) and B (unpaired)
    do_reset();
    wr(3'd0, 16'h0055);
    wr(3'd4, 16'h0035);
    step(5);
    capture_in = 1'b1;
    step(1);
    rd("R8 A captured", 3'd0, 16'd5);
    rd("R8 old A to C", 3'd2, 16'h0055);
    rd("R8 B captured", 3'd1, 16'd5);
    rd("R8 D untouched", 3'd3, 16'd0);
    capture_in = 1'b0;
    step(1);
    capture_in = 1'b1;
    step(1);
    rd("R8 A second capture", 3'd0, 16'd7);
    rd("R8 C second", 3'd2, 16'd5);
    capture_in = 1'b0;

    // R7 / R6: write collision and B/D pairing
    do_reset();
    wr(3'd1, 16'd5);
    wr(3'd0, 16'd2);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd7);
    wr(3'd4, 16'h000F);
    step(2);
    wr(3'd0, 16'h0077);
    rd("R7 copy beats write", 3'd0, 16'd4);
    pin("R4 high at A", 1'b1);
    step(2);
    rd("R6 B before match", 3'd1, 16'd5);
    step(1);
    rd("R6 D copied to B", 3'd1, 16'd7);
    rd("R3 wrap at B", 3'd5, 16'd0);
    pin("R4 low at B", 1'b0);
    step(2);
    cnt_en = 1'b0;
    step(4);
    rd("R2 gated count", 3'd5, 16'd2);
    cnt_en = 1'b1;
    step(1);
    rd("R2 resumes", 3'd5, 16'd3);

    // R5 / R9: unpaired compare
    do_reset();
    wr(3'd1, 16'd3);
    wr(3'd0, 16'd1);
    wr(3'd2, 16'd9);
    wr(3'd4, 16'h0003);
    step(2);
    rd("R5 unpaired A kept", 3'd0, 16'd1);
    pin("R4 unpaired high", 1'b1);
    wr(3'd0, 16'd2);
    rd("R9 direct A write", 3'd0, 16'd2);
    rd("R9 ctrl readback", 3'd4, 16'h0003);
    rd("R9 unmapped", 3'd6, 16'h0000);

    // R4 / R3: A equals B, low wins
    do_reset();
    wr(3'd4, 16'h0003);
    step(3);
    rd("R3 B=0 holds zero", 3'd5, 16'd0);
    pin("R4 tie low", 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule